// File: doc/BRIEF.md
# Dual-Issue Integer/FP Pairing Logic

This block is the issue stage of a two-wide in-order machine. Each cycle, fetch presents a 64-bit group that holds two decoded 32-bit instructions. The left slot may hold any instruction. The right slot is meant for a floating-point operation. The block decides whether to issue both instructions, only the left one, or neither. It then reports how many instructions it consumed, so that fetch can advance by 0, 1 or 2 slots. An instruction that is not consumed is presented again next cycle, in the left slot when the left one has gone.

A load's data arrives one cycle after the load issues. When the load sits in the left slot, its result is therefore unavailable to the right slot of the same group and to both slots of the next issuing cycle. The block remembers the destination of a load it issued in the previous cycle. It holds any slot that reads that destination, together with every slot behind it. Within a group, the right slot also cannot read or overwrite a register that the left slot writes. A floating-point load on the left still pairs with an independent floating-point operation on the right.

Top module: `ipair_issue`

## Requirements
- R1: When `lf_valid` is 0, neither slot issues and `consumed` is 0. A valid left instruction with no load-shadow conflict always issues.
- R2: `issue_right` is never 1 in a cycle in which `issue_left` is 0.
- R3: The right slot can pair only when `rt_valid` is 1, `rt_cls` is FP (2'b10) and `lf_cls` is not FP. The class codes are integer 2'b00, load 2'b01, FP 2'b10 and other 2'b11. Two integer instructions therefore issue one at a time.
- R4: The right slot does not issue when one of its enabled sources equals `lf_dst` while `lf_dst_we` is 1. It also does not issue when both slots write the same destination tag. This covers an FP operation that uses the result of a load in the same group.
- R5: A load on the left paired with an FP operation on the right that does not depend on it issues both, with `consumed` equal to 2.
- R6: A load (class 2'b01, `lf_dst_we`=1) that issues from the left at one clock edge puts its destination into a shadow for the following cycle only. In that cycle, a slot with an enabled source equal to that tag is held, and so is every slot after it. One cycle later the same instruction issues.
- R7: `consumed` always equals the number of strobes asserted, which is 0, 1 or 2.
- R8: A synchronous active-low reset clears the load shadow, so a dependent instruction issues right after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lf_valid | input | 1 | Left slot holds an instruction |
| lf_cls | input | 2 | Left class code |
| lf_src_a | input | TAG_W | Left first source register tag |
| lf_src_b | input | TAG_W | Left second source register tag |
| lf_src_en | input | 2 | Left source enables (bit 0 = a, bit 1 = b) |
| lf_dst | input | TAG_W | Left destination tag |
| lf_dst_we | input | 1 | Left writes its destination |
| rt_valid | input | 1 | Right slot holds an instruction |
| rt_cls | input | 2 | Right class code |
| rt_src_a | input | TAG_W | Right first source tag |
| rt_src_b | input | TAG_W | Right second source tag |
| rt_src_en | input | 2 | Right source enables |
| rt_dst | input | TAG_W | Right destination tag |
| rt_dst_we | input | 1 | Right writes its destination |
| issue_left | output | 1 | Left instruction issues this cycle |
| issue_right | output | 1 | Right instruction issues this cycle |
| consumed | output | 2 | Fetch advance in slots |

## Verification
The strobes and `consumed` are combinational functions of the presented group and the one-entry shadow. Their values are due in the same cycle that the group is driven. The bench drives each group just after a falling edge and samples the outputs a moment later, before the next rising edge. The shadow is written at the rising edge that follows a load's issue and affects only the next group. The bench's model updates its own shadow copy at that same point, which keeps every load-dependent check exactly one issue cycle after the load.

// File: rtl/ipair_pkg.sv
// Shared class codes for the pairing logic.
// Assumes the decoder maps every instruction onto one of four classes.
package ipair_pkg;
    typedef enum logic [1:0] {
        CLS_INT  = 2'b00,
        CLS_LOAD = 2'b01,
        CLS_FP   = 2'b10,
        CLS_MISC = 2'b11
    } icls_e;
endpackage

// File: rtl/ipair_src_hit.sv
// Compares two enabled source tags against one register tag.
// Assumes that cmp_vld qualifies cmp_tag; the result is purely combinational.
module ipair_src_hit #(
    parameter int TAG_W = 6
) (
    input  logic [TAG_W-1:0] src_a,
    input  logic [TAG_W-1:0] src_b,
    input  logic [1:0]       src_en,
    input  logic [TAG_W-1:0] cmp_tag,
    input  logic             cmp_vld,
    output logic             hit
);
    // Raise hit when either enabled source reads the compared tag.
    always_comb begin
        hit = cmp_vld && ((src_en[0] && (src_a == cmp_tag)) ||
                          (src_en[1] && (src_b == cmp_tag)));
    end
endmodule

// File: rtl/ipair_ld_shadow.sv
// One-entry record of the load destination whose data is still in flight.
// Assumes the load delay is one cycle, so an entry lives for exactly one cycle.
module ipair_ld_shadow #(
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_vld,
    input  logic [TAG_W-1:0] set_tag,
    output logic             sh_vld,
    output logic [TAG_W-1:0] sh_tag
);
    // Capture this cycle's issued load; any other cycle drops the entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_vld <= 1'b0;
            sh_tag <= '0;
        end else begin
            sh_vld <= set_vld;
            sh_tag <= set_tag;
        end
    end
endmodule

// File: rtl/ipair_issue.sv
// Issue decision for a two-slot group: any class on the left, FP on the right.
// Assumes that fetch re-presents unconsumed instructions in order, shifted left.
module ipair_issue #(
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lf_valid,
    input  logic [1:0]       lf_cls,
    input  logic [TAG_W-1:0] lf_src_a,
    input  logic [TAG_W-1:0] lf_src_b,
    input  logic [1:0]       lf_src_en,
    input  logic [TAG_W-1:0] lf_dst,
    input  logic             lf_dst_we,
    input  logic             rt_valid,
    input  logic [1:0]       rt_cls,
    input  logic [TAG_W-1:0] rt_src_a,
    input  logic [TAG_W-1:0] rt_src_b,
    input  logic [1:0]       rt_src_en,
    input  logic [TAG_W-1:0] rt_dst,
    input  logic             rt_dst_we,
    output logic             issue_left,
    output logic             issue_right,
    output logic [1:0]       consumed
);
    import ipair_pkg::*;

    localparam int NSLOT = 2;

    logic [NSLOT-1:0][TAG_W-1:0] slot_a, slot_b;
    logic [NSLOT-1:0][1:0]       slot_en;
    logic [NSLOT-1:0]            sh_hit;
    logic                        sh_vld;
    logic [TAG_W-1:0]            sh_tag;
    logic                        raw_hit, waw_hit, cls_ok;

    // Gather both slots' source fields into arrays for the per-slot compare.
    always_comb begin
        slot_a[0]  = lf_src_a;
        slot_b[0]  = lf_src_b;
        slot_en[0] = lf_src_en;
        slot_a[1]  = rt_src_a;
        slot_b[1]  = rt_src_b;
        slot_en[1] = rt_src_en;
    end

    ipair_ld_shadow #(.TAG_W(TAG_W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vld (issue_left && (lf_cls == CLS_LOAD) && lf_dst_we),
        .set_tag (lf_dst),
        .sh_vld  (sh_vld),
        .sh_tag  (sh_tag)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_shadow_cmp
        ipair_src_hit #(.TAG_W(TAG_W)) u_hit (
            .src_a   (slot_a[g]),
            .src_b   (slot_b[g]),
            .src_en  (slot_en[g]),
            .cmp_tag (sh_tag),
            .cmp_vld (sh_vld),
            .hit     (sh_hit[g])
        );
    end

    ipair_src_hit #(.TAG_W(TAG_W)) u_pair_raw (
        .src_a   (rt_src_a),
        .src_b   (rt_src_b),
        .src_en  (rt_src_en),
        .cmp_tag (lf_dst),
        .cmp_vld (lf_dst_we),
        .hit     (raw_hit)
    );

    // Flag two writers of the same tag and check the slot-role rule.
    always_comb begin
        waw_hit = lf_dst_we && rt_dst_we && (lf_dst == rt_dst);
        cls_ok  = (rt_cls == CLS_FP) && (lf_cls != CLS_FP);
    end

    // Issue in order: the left slot first, and the right slot only behind it.
    always_comb begin
        issue_left  = lf_valid && !sh_hit[0];
        issue_right = issue_left && rt_valid && cls_ok && !sh_hit[1] &&
                      !raw_hit && !waw_hit;
        consumed    = {1'b0, issue_left} + {1'b0, issue_right};
    end
endmodule

// File: rtl/ipair_issue_chk.sv
// Checker for the pairing rules, attached to every ipair_issue instance.
module ipair_issue_chk #(
    parameter int TAG_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lf_valid,
    input logic [1:0]       lf_cls,
    input logic [TAG_W-1:0] lf_src_a,
    input logic [1:0]       lf_src_en,
    input logic [TAG_W-1:0] lf_dst,
    input logic             lf_dst_we,
    input logic [1:0]       rt_cls,
    input logic             issue_left,
    input logic             issue_right,
    input logic [1:0]       consumed
);
    logic armed;

    // Mark the cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) armed <= rst_n;

    a_r2_right_needs_left: assert property (@(posedge clk) disable iff (!rst_n)
        issue_right |-> issue_left);

    a_r3_slot_roles: assert property (@(posedge clk) disable iff (!rst_n)
        issue_right |-> (rt_cls == 2'b10) && (lf_cls != 2'b10));

    a_r1_empty_left: assert property (@(posedge clk) disable iff (!rst_n)
        !lf_valid |-> !issue_left && (consumed == 2'd0));

    a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        consumed != 2'd3);

    a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(issue_left) && ($past(lf_cls) == 2'b01) && $past(lf_dst_we) &&
         lf_src_en[0] && (lf_src_a == $past(lf_dst))) |-> !issue_left && !issue_right);
endmodule

bind ipair_issue ipair_issue_chk #(.TAG_W(TAG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lf_valid    (lf_valid),
    .lf_cls      (lf_cls),
    .lf_src_a    (lf_src_a),
    .lf_src_en   (lf_src_en),
    .lf_dst      (lf_dst),
    .lf_dst_we   (lf_dst_we),
    .rt_cls      (rt_cls),
    .issue_left  (issue_left),
    .issue_right (issue_right),
    .consumed    (consumed)
);

// File: tb/ipair_issue_tb.sv
module ipair_issue_tb;
    localparam int TAG_W  = 6;
    localparam int CLK_NS = 10;
    localparam logic [1:0] C_INT = 2'b00, C_LD = 2'b01, C_FP = 2'b10, C_MISC = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lf_valid, lf_dst_we, rt_valid, rt_dst_we;
    logic [1:0] lf_cls, rt_cls, lf_src_en, rt_src_en;
    logic [TAG_W-1:0] lf_src_a, lf_src_b, lf_dst, rt_src_a, rt_src_b, rt_dst;
    logic issue_left, issue_right;
    logic [1:0] consumed;

    int checks = 0;
    int errors = 0;
    logic m_vld = 1'b0;
    logic [TAG_W-1:0] m_tag = '0;

    always #(CLK_NS/2) clk = ~clk;

    ipair_issue #(.TAG_W(TAG_W)) u_dut (.*);

    function automatic logic reads(logic [TAG_W-1:0] a, logic [TAG_W-1:0] b,
                                   logic [1:0] en, logic [TAG_W-1:0] t);
        return (en[0] && a == t) || (en[1] && b == t);
    endfunction

    task automatic drive_l(logic v, logic [1:0] c, logic [TAG_W-1:0] a, logic [TAG_W-1:0] b,
                           logic [1:0] en, logic [TAG_W-1:0] d, logic we);
        lf_valid = v; lf_cls = c; lf_src_a = a; lf_src_b = b;
        lf_src_en = en; lf_dst = d; lf_dst_we = we;
    endtask

    task automatic drive_r(logic v, logic [1:0] c, logic [TAG_W-1:0] a, logic [TAG_W-1:0] b,
                           logic [1:0] en, logic [TAG_W-1:0] d, logic we);
        rt_valid = v; rt_cls = c; rt_src_a = a; rt_src_b = b;
        rt_src_en = en; rt_dst = d; rt_dst_we = we;
    endtask

    // Compare the outputs with the requirement model, then advance the model shadow.
    task automatic check(string req);
        logic el, er;
        logic [1:0] ec;
        #1;
        el = lf_valid && !(m_vld && reads(lf_src_a, lf_src_b, lf_src_en, m_tag));
        er = el && rt_valid && rt_cls == C_FP && lf_cls != C_FP &&
             !(m_vld && reads(rt_src_a, rt_src_b, rt_src_en, m_tag)) &&
             !(lf_dst_we && reads(rt_src_a, rt_src_b, rt_src_en, lf_dst)) &&
             !(lf_dst_we && rt_dst_we && lf_dst == rt_dst);
        ec = {1'b0, el} + {1'b0, er};
        checks++;
        if (issue_left !== el || issue_right !== er || consumed !== ec) begin
            errors++;
            $display("FAIL %s: got L=%b R=%b n=%0d expected L=%b R=%b n=%0d",
                     req, issue_left, issue_right, consumed, el, er, ec);
        end
        m_vld = el && lf_cls == C_LD && lf_dst_we;
        m_tag = lf_dst;
    endtask

    task automatic expect_n(string req, logic [1:0] n);
        checks++;
        if (consumed !== n) begin
            errors++;
            $display("FAIL %s: got n=%0d expected n=%0d", req, consumed, n);
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd11));
        drive_l(0, C_INT, 0, 0, 0, 0, 0);
        drive_r(0, C_FP, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); check("R1 reset idle"); expect_n("R1", 2'd0);
        // R3: integer + FP pair, then integer + integer.
        @(negedge clk); drive_l(1, C_INT, 1, 2, 3, 3, 1); drive_r(1, C_FP, 33, 34, 3, 35, 1);
        check("R3 int+fp"); expect_n("R3", 2'd2);
        @(negedge clk); drive_r(1, C_INT, 4, 5, 3, 6, 1);
        check("R3 int+int"); expect_n("R3", 2'd1);
        // R4: FP op in the same group uses the load result.
        @(negedge clk); drive_l(1, C_LD, 1, 0, 1, 40, 1); drive_r(1, C_FP, 40, 33, 3, 41, 1);
        check("R4 same-group load use"); expect_n("R4", 2'd1);
        // R6: next group, the FP op is now on the left and still reads tag 40.
        @(negedge clk); drive_l(1, C_FP, 40, 33, 3, 41, 1); drive_r(1, C_FP, 50, 51, 3, 52, 1);
        check("R6 shadow holds left and right"); expect_n("R6", 2'd0);
        @(negedge clk); check("R6 shadow expired"); expect_n("R6", 2'd1);
        // R5: FP load pairs with an independent FP op.
        @(negedge clk); drive_l(1, C_LD, 2, 0, 1, 42, 1); drive_r(1, C_FP, 33, 34, 3, 43, 1);
        check("R5 fp load + fp op"); expect_n("R5", 2'd2);
        // R6/R2: left free, right reads the shadow tag; left stall blocks right.
        @(negedge clk); drive_l(1, C_INT, 1, 2, 3, 5, 1); drive_r(1, C_FP, 33, 42, 3, 44, 1);
        check("R6 right-only shadow hit"); expect_n("R6", 2'd1);
        @(negedge clk); drive_l(1, C_LD, 1, 0, 1, 7, 1); drive_r(0, C_FP, 0, 0, 0, 60, 0);
        check("R1 load alone");
        @(negedge clk); drive_l(1, C_INT, 7, 2, 1, 8, 1); drive_r(1, C_FP, 33, 34, 3, 45, 1);
        check("R2 left stall blocks right"); expect_n("R2", 2'd0);
        // R4: write-after-write inside a group.
        @(negedge clk); drive_l(1, C_MISC, 1, 2, 3, 46, 1); drive_r(1, C_FP, 33, 34, 3, 46, 1);
        check("R4 same dst"); expect_n("R4", 2'd1);
        // R8: reset clears a live shadow.
        @(negedge clk); drive_l(1, C_LD, 1, 0, 1, 9, 1); drive_r(0, C_FP, 0, 0, 0, 0, 0);
        check("R8 load before reset");
        rst_n = 1'b0; m_vld = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        drive_l(1, C_INT, 9, 9, 3, 10, 1);
        check("R8 shadow cleared"); expect_n("R8", 2'd1);
        // R7: random mix with narrow tags so that conflicts are frequent.
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            drive_l($urandom % 8 != 0, 2'($urandom), TAG_W'($urandom % 4), TAG_W'($urandom % 4),
                    2'($urandom), TAG_W'($urandom % 4), 1'($urandom));
            drive_r($urandom % 8 != 0, 2'($urandom), TAG_W'($urandom % 4), TAG_W'($urandom % 4),
                    2'($urandom), TAG_W'($urandom % 4), 1'($urandom));
            check("R7 random");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule